// File: doc/BRIEF.md
# Serial Loopback and Echo Router

This block sits between a serial transmitter, a serial receiver, the modem handshake pins and the CPU character paths of a serial port. A two-bit submode field selects one of four routings: normal, automatic echo, local loopback and remote loopback. The selected routing steers serial bits, baud-clock enables, modem handshakes and received characters, and it raises override flags for the ready and empty indications that status logic elsewhere builds. The shift registers and the status register are not part of this block.

Characters move on valid/ready streams. A source holds valid and data stable until ready is seen in the same cycle. When a received character goes to both the CPU and the transmit holding register, the fork has no buffer. The character is taken only when every enabled consumer is ready. Each consumer's valid is held off until the other consumer is ready, so neither one takes a copy alone.

Baud-clock selection is registered. A new selection takes effect only while the shifter concerned reports idle, so a character is never shifted with mixed clocks. All other routing follows the submode field in the same cycle.

Top module: `serial_loop_router`

## Requirements
- R1: Submode encoding is 0 normal, 1 echo, 2 local loopback, 3 remote loopback. Value 1 selects echo only when `sync_mode` is 0. With `sync_mode` 1, value 1 routes exactly like normal.
- R2: Normal routing: `cpu_tx_*` connects to `thr_*`, `rxc_*` connects to `cpu_rx_*`, `txd_pin` follows `tx_bit`, `rx_bit` follows `rxd_pin`, and each modem line passes straight through. `tx_en_eff` follows `tx_en` and `rx_en_eff` follows `rx_en`. All override flags are 0.
- R3: Echo routing: each received character is forked to both `cpu_rx_*` and `thr_*`. `rxc_ready` = `cpu_rx_ready` AND `thr_ready`. `cpu_rx_valid` = `rxc_valid` AND `thr_ready`. `thr_valid` = `rxc_valid` AND `cpu_rx_ready`. `thr_data` = `rxc_data`, and `cpu_tx_ready` is 0.
- R4: In echo, `tx_en_eff` is 1 whatever `tx_en` is. `txrdy_force` and `dschg_only` are 1, and `rxrdy_force` and `txemt_force` are 0.
- R5: In echo, the first break character (`rxc_break`=1) taken is forwarded to `thr`. Later break characters go to the CPU only, with `thr_valid` 0 and `rxc_ready` = `cpu_rx_ready`. `txd_pin` is held at 1 while `tx_idle` is 1. The next `rx_start` pulse, or leaving echo, ends this state.
- R6: Local loopback: `rx_bit` = `tx_bit`. `txd_pin`, `dtr_pin` and `rts_pin` are 1. `dcd_int` = `dtr_bit`, `cts_int` = `rts_bit` and `dsr_int` = 0, so the modem input pins and `rxd_pin` are ignored. `rx_en_eff` is 1, `tx_en_eff` follows `tx_en`, and the character streams route as in normal.
- R7: Remote loopback: received characters go only to `thr`. `cpu_rx_valid` is 0, `rxc_ready` = `thr_ready` and `cpu_tx_ready` is 0. `txrdy_force`, `rxrdy_force`, `txemt_force` and `tx_en_eff` are 1, and pins and modem lines pass through as in normal.
- R8: `tx_clk_from_rx` targets 1 in echo or remote, and `rx_clk_from_tx` targets 1 in local loopback. Each selection loads its target at a clock edge where its `*_idle` is 1, and holds its value otherwise. `tx_tick` = `tx_clk_from_rx ? rx_tick_in : tx_tick_in`, and `rx_tick` = `rx_clk_from_tx ? tx_tick_in : rx_tick_in`.
- R9: During reset both clock selections are 0 and no break is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sub_mode | input | 2 | Submode field |
| sync_mode | input | 1 | 1 = synchronous major mode |
| tx_en | input | 1 | Transmit enable bit |
| rx_en | input | 1 | Receive enable bit |
| dtr_bit | input | 1 | Terminal-ready command bit |
| rts_bit | input | 1 | Request-to-send command bit |
| tx_tick_in | input | 1 | Transmit baud enable |
| rx_tick_in | input | 1 | Receive baud enable |
| tx_idle | input | 1 | Transmit shifter between characters |
| rx_idle | input | 1 | Receive shifter between characters |
| tx_tick | output | 1 | Baud enable routed to the transmitter |
| rx_tick | output | 1 | Baud enable routed to the receiver |
| tx_clk_from_rx | output | 1 | Transmitter runs on the receive clock |
| rx_clk_from_tx | output | 1 | Receiver runs on the transmit clock |
| tx_bit | input | 1 | Serial bit from the transmitter |
| rxd_pin | input | 1 | Receive data pin |
| txd_pin | output | 1 | Transmit data pin |
| rx_bit | output | 1 | Serial bit to the receiver |
| dtr_pin | output | 1 | Terminal-ready pin |
| rts_pin | output | 1 | Request-to-send pin |
| cts_pin | input | 1 | Clear-to-send pin |
| dcd_pin | input | 1 | Carrier-detect pin |
| dsr_pin | input | 1 | Set-ready pin |
| cts_int | output | 1 | Clear-to-send seen by the core |
| dcd_int | output | 1 | Carrier-detect seen by the core |
| dsr_int | output | 1 | Set-ready seen by the core |
| rx_start | input | 1 | Pulse: receiver found a valid start bit |
| rxc_valid | input | 1 | Received character valid |
| rxc_break | input | 1 | Received character is a break |
| rxc_data | input | 8 | Received character |
| rxc_ready | output | 1 | Received character taken |
| cpu_rx_valid | output | 1 | Character offered to the CPU |
| cpu_rx_data | output | 8 | Character to the CPU |
| cpu_rx_ready | input | 1 | CPU takes the character |
| cpu_tx_valid | input | 1 | CPU offers a character to send |
| cpu_tx_data | input | 8 | CPU character to send |
| cpu_tx_ready | output | 1 | CPU character taken |
| thr_valid | output | 1 | Character offered to the transmit holding register |
| thr_data | output | 8 | Character to the transmit holding register |
| thr_ready | input | 1 | Transmit holding register takes it |
| tx_en_eff | output | 1 | Effective transmit enable |
| rx_en_eff | output | 1 | Effective receive enable |
| txrdy_force | output | 1 | Hold transmit-ready indication high |
| rxrdy_force | output | 1 | Hold receive-ready indication high |
| txemt_force | output | 1 | Hold transmit-empty indication high |
| dschg_only | output | 1 | Empty indication shows modem change only |

## Verification
The combinational routing is swept over all four submodes, both major modes and every value of the enable bits, the serial bits, the modem lines and the stream handshakes. This sweep separates the four routings from one another, and it separates echo from the synchronous use of the same code. The clock selection is tried with the shifter busy and then idle, which shows whether a change waits for a character boundary. A run of break characters followed by a start pulse shows that only the first break is echoed, that the line is then held marking, and that the hold is released.

// File: rtl/slr_pkg.sv
package slr_pkg;
  typedef enum logic [1:0] {
    SM_NORMAL = 2'd0,
    SM_ECHO   = 2'd1,
    SM_LLOOP  = 2'd2,
    SM_RLOOP  = 2'd3
  } submode_e;

  typedef struct packed {
    logic echo;
    logic lloop;
    logic rloop;
  } route_t;

  function automatic route_t decode_route(logic [1:0] sm, logic sync);
    route_t r;
    r.echo  = (submode_e'(sm) == SM_ECHO) && !sync;
    r.lloop = (submode_e'(sm) == SM_LLOOP);
    r.rloop = (submode_e'(sm) == SM_RLOOP);
    return r;
  endfunction
endpackage

// File: rtl/slr_clk_sel.sv
module slr_clk_sel #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] idle,
  input  logic [N-1:0] want,
  output logic [N-1:0] sel
);
  for (genvar g = 0; g < N; g++) begin : g_sel
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel[g] <= 1'b0;
      else if (idle[g]) sel[g] <= want[g];
    end
  end
endmodule

// File: rtl/slr_char_path.sv
module slr_char_path
  import slr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  route_t        rt,
  input  logic          rx_start,
  input  logic          rxc_valid,
  input  logic          rxc_break,
  input  logic [DW-1:0] rxc_data,
  output logic          rxc_ready,
  output logic          cpu_rx_valid,
  output logic [DW-1:0] cpu_rx_data,
  input  logic          cpu_rx_ready,
  input  logic          cpu_tx_valid,
  input  logic [DW-1:0] cpu_tx_data,
  output logic          cpu_tx_ready,
  output logic          thr_valid,
  output logic [DW-1:0] thr_data,
  input  logic          thr_ready,
  output logic          brk_pending
);
  logic back;
  logic fwd;

  assign back = rt.echo | rt.rloop;
  assign fwd  = !(rt.echo && rxc_break && brk_pending);

  always_comb begin
    cpu_rx_data  = rxc_data;
    thr_data     = back ? rxc_data : cpu_tx_data;
    cpu_tx_ready = back ? 1'b0 : thr_ready;
    if (rt.rloop) begin
      cpu_rx_valid = 1'b0;
      thr_valid    = rxc_valid;
      rxc_ready    = thr_ready;
    end else if (rt.echo) begin
      cpu_rx_valid = rxc_valid & (thr_ready | !fwd);
      thr_valid    = rxc_valid & cpu_rx_ready & fwd;
      rxc_ready    = cpu_rx_ready & (thr_ready | !fwd);
    end else begin
      cpu_rx_valid = rxc_valid;
      thr_valid    = cpu_tx_valid;
      rxc_ready    = cpu_rx_ready;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      brk_pending <= 1'b0;
    else if (!rt.echo || rx_start)
      brk_pending <= 1'b0;
    else if (rxc_valid && rxc_ready && rxc_break)
      brk_pending <= 1'b1;
  end
endmodule

// File: rtl/slr_pin_mux.sv
module slr_pin_mux
  import slr_pkg::*;
(
  input  route_t rt,
  input  logic   brk_hold,
  input  logic   tx_bit,
  input  logic   rxd_pin,
  input  logic   dtr_bit,
  input  logic   rts_bit,
  input  logic   cts_pin,
  input  logic   dcd_pin,
  input  logic   dsr_pin,
  input  logic   tx_en,
  input  logic   rx_en,
  output logic   txd_pin,
  output logic   rx_bit,
  output logic   dtr_pin,
  output logic   rts_pin,
  output logic   cts_int,
  output logic   dcd_int,
  output logic   dsr_int,
  output logic   tx_en_eff,
  output logic   rx_en_eff,
  output logic   txrdy_force,
  output logic   rxrdy_force,
  output logic   txemt_force,
  output logic   dschg_only
);
  always_comb begin
    txd_pin     = (rt.lloop | brk_hold) ? 1'b1 : tx_bit;
    rx_bit      = rt.lloop ? tx_bit  : rxd_pin;
    dtr_pin     = rt.lloop ? 1'b1    : dtr_bit;
    rts_pin     = rt.lloop ? 1'b1    : rts_bit;
    dcd_int     = rt.lloop ? dtr_bit : dcd_pin;
    cts_int     = rt.lloop ? rts_bit : cts_pin;
    dsr_int     = rt.lloop ? 1'b0    : dsr_pin;
    tx_en_eff   = (rt.echo | rt.rloop) ? 1'b1 : tx_en;
    rx_en_eff   = rt.lloop ? 1'b1 : rx_en;
    txrdy_force = rt.echo | rt.rloop;
    rxrdy_force = rt.rloop;
    txemt_force = rt.rloop;
    dschg_only  = rt.echo;
  end
endmodule

// File: rtl/serial_loop_router.sv
module serial_loop_router
  import slr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    sub_mode,
  input  logic          sync_mode,
  input  logic          tx_en,
  input  logic          rx_en,
  input  logic          dtr_bit,
  input  logic          rts_bit,
  input  logic          tx_tick_in,
  input  logic          rx_tick_in,
  input  logic          tx_idle,
  input  logic          rx_idle,
  output logic          tx_tick,
  output logic          rx_tick,
  output logic          tx_clk_from_rx,
  output logic          rx_clk_from_tx,
  input  logic          tx_bit,
  input  logic          rxd_pin,
  output logic          txd_pin,
  output logic          rx_bit,
  output logic          dtr_pin,
  output logic          rts_pin,
  input  logic          cts_pin,
  input  logic          dcd_pin,
  input  logic          dsr_pin,
  output logic          cts_int,
  output logic          dcd_int,
  output logic          dsr_int,
  input  logic          rx_start,
  input  logic          rxc_valid,
  input  logic          rxc_break,
  input  logic [DW-1:0] rxc_data,
  output logic          rxc_ready,
  output logic          cpu_rx_valid,
  output logic [DW-1:0] cpu_rx_data,
  input  logic          cpu_rx_ready,
  input  logic          cpu_tx_valid,
  input  logic [DW-1:0] cpu_tx_data,
  output logic          cpu_tx_ready,
  output logic          thr_valid,
  output logic [DW-1:0] thr_data,
  input  logic          thr_ready,
  output logic          tx_en_eff,
  output logic          rx_en_eff,
  output logic          txrdy_force,
  output logic          rxrdy_force,
  output logic          txemt_force,
  output logic          dschg_only
);
  localparam int NSEL = 2;

  route_t          rt;
  logic [NSEL-1:0] sel;
  logic            brk_pending;

  assign rt = decode_route(sub_mode, sync_mode);

  // index 0: transmitter clock source, index 1: receiver clock source
  slr_clk_sel #(.N(NSEL)) u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .idle  ({rx_idle, tx_idle}),
    .want  ({rt.lloop, rt.echo | rt.rloop}),
    .sel   (sel)
  );

  assign tx_clk_from_rx = sel[0];
  assign rx_clk_from_tx = sel[1];
  assign tx_tick = sel[0] ? rx_tick_in : tx_tick_in;
  assign rx_tick = sel[1] ? tx_tick_in : rx_tick_in;

  slr_char_path #(.DW(DW)) u_chr (
    .clk          (clk),
    .rst_n        (rst_n),
    .rt           (rt),
    .rx_start     (rx_start),
    .rxc_valid    (rxc_valid),
    .rxc_break    (rxc_break),
    .rxc_data     (rxc_data),
    .rxc_ready    (rxc_ready),
    .cpu_rx_valid (cpu_rx_valid),
    .cpu_rx_data  (cpu_rx_data),
    .cpu_rx_ready (cpu_rx_ready),
    .cpu_tx_valid (cpu_tx_valid),
    .cpu_tx_data  (cpu_tx_data),
    .cpu_tx_ready (cpu_tx_ready),
    .thr_valid    (thr_valid),
    .thr_data     (thr_data),
    .thr_ready    (thr_ready),
    .brk_pending  (brk_pending)
  );

  slr_pin_mux u_pin (
    .rt          (rt),
    .brk_hold    (rt.echo & brk_pending & tx_idle),
    .tx_bit      (tx_bit),
    .rxd_pin     (rxd_pin),
    .dtr_bit     (dtr_bit),
    .rts_bit     (rts_bit),
    .cts_pin     (cts_pin),
    .dcd_pin     (dcd_pin),
    .dsr_pin     (dsr_pin),
    .tx_en       (tx_en),
    .rx_en       (rx_en),
    .txd_pin     (txd_pin),
    .rx_bit      (rx_bit),
    .dtr_pin     (dtr_pin),
    .rts_pin     (rts_pin),
    .cts_int     (cts_int),
    .dcd_int     (dcd_int),
    .dsr_int     (dsr_int),
    .tx_en_eff   (tx_en_eff),
    .rx_en_eff   (rx_en_eff),
    .txrdy_force (txrdy_force),
    .rxrdy_force (rxrdy_force),
    .txemt_force (txemt_force),
    .dschg_only  (dschg_only)
  );
endmodule

// File: rtl/slr_checker.sv
module slr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] sub_mode,
  input logic       sync_mode,
  input logic       tx_idle,
  input logic       rx_idle,
  input logic       tx_clk_from_rx,
  input logic       rx_clk_from_tx,
  input logic       cpu_rx_valid,
  input logic       cpu_tx_ready,
  input logic       txd_pin,
  input logic       dtr_pin,
  input logic       rts_pin,
  input logic       txrdy_force,
  input logic       rxrdy_force
);
  a_r8_tx_sel_waits: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_idle |=> $stable(tx_clk_from_rx));

  a_r8_rx_sel_waits: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_idle |=> $stable(rx_clk_from_tx));

  a_r7_no_cpu_data: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_mode == 2'd3) |-> (!cpu_rx_valid && !cpu_tx_ready && rxrdy_force));

  a_r3_cpu_tx_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_mode == 2'd1 && !sync_mode) |-> (!cpu_tx_ready && txrdy_force));

  a_r6_pins_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_mode == 2'd2) |-> (txd_pin && dtr_pin && rts_pin));
endmodule

bind serial_loop_router slr_checker u_chk (.*);

// File: tb/sim_serial_loop_router.sv
module sim_serial_loop_router;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] sub_mode = '0;
  logic sync_mode = 0, tx_en = 0, rx_en = 0, dtr_bit = 0, rts_bit = 0;
  logic tx_tick_in = 0, rx_tick_in = 0, tx_idle = 0, rx_idle = 0;
  logic tx_tick, rx_tick, tx_clk_from_rx, rx_clk_from_tx;
  logic tx_bit = 1, rxd_pin = 1, txd_pin, rx_bit, dtr_pin, rts_pin;
  logic cts_pin = 0, dcd_pin = 0, dsr_pin = 0, cts_int, dcd_int, dsr_int;
  logic rx_start = 0, rxc_valid = 0, rxc_break = 0, rxc_ready;
  logic [7:0] rxc_data = 8'hA5, cpu_rx_data, cpu_tx_data = 8'h3C, thr_data;
  logic cpu_rx_valid, cpu_rx_ready = 0, cpu_tx_valid = 0, cpu_tx_ready;
  logic thr_valid, thr_ready = 0;
  logic tx_en_eff, rx_en_eff, txrdy_force, rxrdy_force, txemt_force, dschg_only;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  serial_loop_router u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic ec, lo, rl, bk;
    string tag;
    // R9: reset state
    @(negedge clk);
    check("R9", {30'd0, tx_clk_from_rx, rx_clk_from_tx}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", {31'd0, txd_pin}, 32'd1);

    // R1 R2 R3 R4 R6 R7: exhaustive combinational sweep, clock selections stay 0
    for (int v = 0; v < 65536; v++) begin
      sub_mode = v[1:0]; sync_mode = v[2];
      tx_tick_in = v[3]; rx_tick_in = ~v[3];
      tx_en = v[3]; rx_en = v[4]; dtr_bit = v[5]; rts_bit = v[6];
      tx_bit = v[7]; rxd_pin = v[8]; cts_pin = v[9]; dcd_pin = v[10];
      dsr_pin = v[11]; rxc_valid = v[12]; cpu_rx_ready = v[13];
      thr_ready = v[14]; cpu_tx_valid = v[15];
      #1;
      ec = (v[1:0] == 2'd1) && !v[2];
      lo = (v[1:0] == 2'd2);
      rl = (v[1:0] == 2'd3);
      bk = ec | rl;
      tag = ec ? "R3" : lo ? "R6" : rl ? "R7" : (v[1:0] == 2'd1) ? "R1" : "R2";
      check(tag,
        {19'd0, cpu_rx_valid, rxc_ready, thr_valid, cpu_tx_ready, thr_data, cpu_rx_data[0]},
        {19'd0,
         rl ? 1'b0 : ec ? (rxc_valid & thr_ready) : rxc_valid,
         rl ? thr_ready : ec ? (cpu_rx_ready & thr_ready) : cpu_rx_ready,
         rl ? rxc_valid : ec ? (rxc_valid & cpu_rx_ready) : cpu_tx_valid,
         bk ? 1'b0 : thr_ready,
         bk ? 8'hA5 : 8'h3C, 1'b1});
      check(tag,
        {23'd0, txd_pin, rx_bit, dtr_pin, rts_pin, cts_int, dcd_int, dsr_int, tx_tick, rx_tick},
        {23'd0, lo ? 1'b1 : tx_bit, lo ? tx_bit : rxd_pin,
         lo ? 1'b1 : dtr_bit, lo ? 1'b1 : rts_bit,
         lo ? rts_bit : cts_pin, lo ? dtr_bit : dcd_pin, lo ? 1'b0 : dsr_pin,
         tx_tick_in, rx_tick_in});
      check(ec ? "R4" : tag,
        {26'd0, tx_en_eff, rx_en_eff, txrdy_force, rxrdy_force, txemt_force, dschg_only},
        {26'd0, bk ? 1'b1 : tx_en, lo ? 1'b1 : rx_en, bk, rl, rl, ec});
    end

    // R8: clock selection waits for idle
    @(negedge clk);
    rxc_valid = 0; cpu_tx_valid = 0; tx_idle = 0; rx_idle = 0;
    sub_mode = 2'd3; sync_mode = 0; tx_tick_in = 0; rx_tick_in = 1;
    @(negedge clk);
    check("R8", {31'd0, tx_clk_from_rx}, 32'd0);
    check("R8", {31'd0, tx_tick}, 32'd0);
    tx_idle = 1;
    @(negedge clk);
    check("R8", {31'd0, tx_clk_from_rx}, 32'd1);
    check("R8", {31'd0, tx_tick}, 32'd1);
    sub_mode = 2'd2; tx_idle = 0; rx_idle = 1;
    @(negedge clk);
    check("R8", {30'd0, tx_clk_from_rx, rx_clk_from_tx}, 32'd3);
    check("R8", {31'd0, rx_tick}, 32'd0);
    tx_idle = 1;
    @(negedge clk);
    check("R8", {31'd0, tx_clk_from_rx}, 32'd0);

    // R5: only the first break is echoed, then line held marking
    tx_idle = 0; rx_idle = 0; sub_mode = 2'd1; sync_mode = 0; rx_en = 1;
    cpu_rx_ready = 1; thr_ready = 1; tx_bit = 0;
    @(negedge clk);
    rxc_valid = 1; rxc_break = 1;
    #1;
    check("R5", {31'd0, thr_valid}, 32'd1);
    @(negedge clk);
    check("R5", {29'd0, thr_valid, cpu_rx_valid, rxc_ready}, 32'd3);
    thr_ready = 0;
    #1;
    check("R5", {30'd0, cpu_rx_valid, rxc_ready}, 32'd3);
    thr_ready = 1;
    check("R5", {31'd0, txd_pin}, 32'd0);
    tx_idle = 1;
    #1;
    check("R5", {31'd0, txd_pin}, 32'd1);
    rxc_valid = 0; rx_start = 1;
    @(negedge clk);
    rx_start = 0;
    #1;
    check("R5", {31'd0, txd_pin}, 32'd0);
    rxc_valid = 1;
    #1;
    check("R5", {31'd0, thr_valid}, 32'd1);
    rxc_valid = 0; rxc_break = 0;

    @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule